// File: doc/BRIEF.md
# Dual-Processor Mailbox with Hardware Mutex

This block sits between two processors and lets each one signal the other. It holds one 32-bit request word for each destination processor. Either processor may raise bits in a word by writing to that word's set address, or drop bits by writing to its clear address. The interrupt line toward the processor that owns a word stays high as long as any bit of that word is one. Software can give each bit its own meaning, such as "buffer full" or "command posted".

The block also holds a one-bit hardware mutex that works as an atomic test-and-set. A processor that wants a shared resource reads the mutex. If the read returns 1, that processor now owns the resource, and the read itself has already cleared the flag to 0. To release the resource, the owner writes any value to the mutex, which sets the flag back to 1. A read that returns 0 means the resource is busy.

Each processor reaches the block through its own synchronous register port, with address, write enable, read enable, write data and read data. Byte addresses are 8 bits wide:

| Address | Register |
|---|---|
| 0x10 | request word toward processor 0 |
| 0x14 | set address for that word |
| 0x18 | clear address for that word |
| 0x30 | request word toward processor 1 |
| 0x34 | set address for that word |
| 0x38 | clear address for that word |
| 0xF8 | mutex |

The bank toward processor 1 sits 0x20 above the bank toward processor 0.

Top module: `dual_cpu_mailbox`

## Requirements
- R1: After synchronous reset, both request words are zero, both interrupt lines are low, both read data outputs are zero, and the mutex holds 1.
- R2: A write to a set address (0x14 or 0x30+0x04) ORs the one bits of the write data into that request word. Zero bits leave the matching request bits unchanged.
- R3: A write to a clear address (0x18 or 0x38) clears each request bit whose write data bit is one. All other bits keep their value.
- R4: An interrupt line is high exactly when the request word of its processor is nonzero. The line changes one clock after the write that changes the word.
- R5: If a set and a clear reach the same request bit in the same cycle, from either port, the bit ends up at 1.
- R6: Read data is registered and appears one clock after the read enable.
  - A read of a request word (0x10 or 0x30) returns its value and does not change it.
  - A read of a set or clear address returns zero.
  - Read data holds its value while read enable is low.
- R7: A read of the mutex (0xF8) returns the flag in bit 0 with bits 31:1 zero, and clears the flag to 0.
- R8: Any write to the mutex sets the flag to 1, whatever the write data. When a mutex write and a mutex read happen in the same cycle, the read returns the old flag value and the flag ends up at 1.
- R9: When both ports read the mutex in the same cycle while it is 1, port 0 receives 1 and port 1 receives 0.
- R10: Two ports setting different bits of one word in the same cycle both take effect. An address outside the map reads as zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p0_addr | input | 8 | Port 0 byte address |
| p0_wr | input | 1 | Port 0 write enable |
| p0_rd | input | 1 | Port 0 read enable |
| p0_wdata | input | 32 | Port 0 write data |
| p0_rdata | output | 32 | Port 0 registered read data |
| p1_addr | input | 8 | Port 1 byte address |
| p1_wr | input | 1 | Port 1 write enable |
| p1_rd | input | 1 | Port 1 read enable |
| p1_wdata | input | 32 | Port 1 write data |
| p1_rdata | output | 32 | Port 1 registered read data |
| irq0_o | output | 1 | Interrupt toward processor 0 |
| irq1_o | output | 1 | Interrupt toward processor 1 |

## Verification
The request words are driven with sparse patterns that are then partly cleared, so a clear that is too wide or too narrow shows up in the read-back value. The same bit is set from one port and cleared from the other in one cycle; this separates set-wins from clear-wins. Both ports also set disjoint bits of one word in one cycle; this exposes a merge that drops one port. The mutex is read singly, read by both ports at once, and written while being read; these cases tell apart the port priority, the read-clears side effect and the write-over-read ordering.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int NDEST       = 2;
  localparam int MAP_W       = 8;
  localparam logic [MAP_W-1:0] OFS_WORD    = 8'h10;
  localparam logic [MAP_W-1:0] OFS_SET     = 8'h14;
  localparam logic [MAP_W-1:0] OFS_CLR     = 8'h18;
  localparam logic [MAP_W-1:0] BANK_STRIDE = 8'h20;
  localparam logic [MAP_W-1:0] OFS_MUTEX   = 8'hF8;

  typedef struct packed {
    logic [NDEST-1:0] set_hit;
    logic [NDEST-1:0] clr_hit;
    logic [NDEST-1:0] word_rd;
    logic             mtx_rd;
    logic             mtx_wr;
  } port_dec_t;
endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output port_dec_t         dec_o
);
  localparam int BANKS = NDEST;

  always_comb begin
    dec_o = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (addr_i == ADDR_W'(OFS_SET + MAP_W'(b) * BANK_STRIDE)) dec_o.set_hit[b] = wr_i;
      if (addr_i == ADDR_W'(OFS_CLR + MAP_W'(b) * BANK_STRIDE)) dec_o.clr_hit[b] = wr_i;
      if (addr_i == ADDR_W'(OFS_WORD + MAP_W'(b) * BANK_STRIDE)) dec_o.word_rd[b] = rd_i;
    end
    if (addr_i == ADDR_W'(OFS_MUTEX)) begin
      dec_o.mtx_rd = rd_i;
      dec_o.mtx_wr = wr_i;
    end
  end
endmodule

// File: rtl/mbx_req_word.sv
module mbx_req_word #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] set0_i,
  input  logic [DATA_W-1:0] set1_i,
  input  logic [DATA_W-1:0] clr0_i,
  input  logic [DATA_W-1:0] clr1_i,
  output logic [DATA_W-1:0] word_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] word_d;
  logic              irq_q;

  // clear first, then set: a set on the same bit wins
  always_comb word_d = (word_q & ~(clr0_i | clr1_i)) | set0_i | set1_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      irq_q  <= |word_d;
    end
  end

  assign word_o = word_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/mbx_mutex.sv
module mbx_mutex (
  input  logic clk,
  input  logic rst,
  input  logic rd0_i,
  input  logic rd1_i,
  input  logic wr_i,
  output logic val0_o,
  output logic val1_o,
  output logic state_o
);
  logic flag_q;

  // port 0 has priority when both test in one cycle
  assign val0_o  = flag_q;
  assign val1_o  = flag_q & ~rd0_i;
  assign state_o = flag_q;

  always_ff @(posedge clk) begin
    if (rst)                 flag_q <= 1'b1;
    else if (wr_i)           flag_q <= 1'b1;
    else if (rd0_i || rd1_i) flag_q <= 1'b0;
  end
endmodule

// File: rtl/mbx_rd_reg.sv
module mbx_rd_reg
  import mbx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  logic [NDEST-1:0]  word_sel_i,
  input  logic              mtx_sel_i,
  input  logic              mtx_val_i,
  input  logic [DATA_W-1:0] word0_i,
  input  logic [DATA_W-1:0] word1_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mux_d;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    mux_d = '0;
    if (word_sel_i[0]) mux_d = word0_i;
    if (word_sel_i[1]) mux_d = word1_i;
    if (mtx_sel_i)     mux_d = DATA_W'(mtx_val_i);
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_q <= '0;
    else if (rd_i) rdata_q <= mux_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/dual_cpu_mailbox.sv
module dual_cpu_mailbox
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] p0_addr,
  input  logic              p0_wr,
  input  logic              p0_rd,
  input  logic [DATA_W-1:0] p0_wdata,
  output logic [DATA_W-1:0] p0_rdata,
  input  logic [ADDR_W-1:0] p1_addr,
  input  logic              p1_wr,
  input  logic              p1_rd,
  input  logic [DATA_W-1:0] p1_wdata,
  output logic [DATA_W-1:0] p1_rdata,
  output logic              irq0_o,
  output logic              irq1_o
);
  localparam int NPORT = 2;

  logic [ADDR_W-1:0] addr  [NPORT];
  logic              wr    [NPORT];
  logic              rd    [NPORT];
  logic [DATA_W-1:0] wdata [NPORT];
  logic [DATA_W-1:0] rdata [NPORT];
  port_dec_t         dec   [NPORT];
  logic [DATA_W-1:0] setm  [NPORT][NDEST];
  logic [DATA_W-1:0] clrm  [NPORT][NDEST];
  logic [DATA_W-1:0] word  [NDEST];
  logic [NDEST-1:0]  irq;
  logic              mtx_val [NPORT];
  logic              mtx_state;

  assign addr[0]  = p0_addr;
  assign addr[1]  = p1_addr;
  assign wr[0]    = p0_wr;
  assign wr[1]    = p1_wr;
  assign rd[0]    = p0_rd;
  assign rd[1]    = p1_rd;
  assign wdata[0] = p0_wdata;
  assign wdata[1] = p1_wdata;
  assign p0_rdata = rdata[0];
  assign p1_rdata = rdata[1];
  assign irq0_o   = irq[0];
  assign irq1_o   = irq[1];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    mbx_port_dec #(.ADDR_W(ADDR_W)) u_dec (
      .addr_i (addr[p]),
      .wr_i   (wr[p]),
      .rd_i   (rd[p]),
      .dec_o  (dec[p])
    );
    for (genvar b = 0; b < NDEST; b++) begin : g_mask
      assign setm[p][b] = dec[p].set_hit[b] ? wdata[p] : '0;
      assign clrm[p][b] = dec[p].clr_hit[b] ? wdata[p] : '0;
    end
  end

  for (genvar b = 0; b < NDEST; b++) begin : g_dest
    mbx_req_word #(.DATA_W(DATA_W)) u_word (
      .clk    (clk),
      .rst    (rst),
      .set0_i (setm[0][b]),
      .set1_i (setm[1][b]),
      .clr0_i (clrm[0][b]),
      .clr1_i (clrm[1][b]),
      .word_o (word[b]),
      .irq_o  (irq[b])
    );
  end

  mbx_mutex u_mtx (
    .clk     (clk),
    .rst     (rst),
    .rd0_i   (dec[0].mtx_rd),
    .rd1_i   (dec[1].mtx_rd),
    .wr_i    (dec[0].mtx_wr | dec[1].mtx_wr),
    .val0_o  (mtx_val[0]),
    .val1_o  (mtx_val[1]),
    .state_o (mtx_state)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    mbx_rd_reg #(.DATA_W(DATA_W)) u_rd (
      .clk        (clk),
      .rst        (rst),
      .rd_i       (rd[p]),
      .word_sel_i (dec[p].word_rd),
      .mtx_sel_i  (dec[p].mtx_rd),
      .mtx_val_i  (mtx_val[p]),
      .word0_i    (word[0]),
      .word1_i    (word[1]),
      .rdata_o    (rdata[p])
    );
  end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] p0_addr,
  input logic              p0_wr,
  input logic              p0_rd,
  input logic [DATA_W-1:0] p0_wdata,
  input logic [DATA_W-1:0] p0_rdata,
  input logic [ADDR_W-1:0] p1_addr,
  input logic              p1_wr,
  input logic              p1_rd,
  input logic [DATA_W-1:0] p1_wdata,
  input logic [DATA_W-1:0] p1_rdata,
  input logic              irq0_o,
  input logic              irq1_o,
  input logic              mtx_state
);
  localparam logic [ADDR_W-1:0] A_SET0 = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_SET1 = ADDR_W'(8'h34);
  localparam logic [ADDR_W-1:0] A_MTX  = ADDR_W'(8'hF8);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (mtx_state && !irq0_o && !irq1_o && p0_rdata == '0 && p1_rdata == '0));

  a_r4_set_raises_irq0: assert property (@(posedge clk) disable iff (rst)
    ((p0_wr && p0_addr == A_SET0 && p0_wdata != '0) ||
     (p1_wr && p1_addr == A_SET0 && p1_wdata != '0)) |=> irq0_o);

  a_r4_set_raises_irq1: assert property (@(posedge clk) disable iff (rst)
    ((p0_wr && p0_addr == A_SET1 && p0_wdata != '0) ||
     (p1_wr && p1_addr == A_SET1 && p1_wdata != '0)) |=> irq1_o);

  a_r7_mutex_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (p0_rd && p0_addr == A_MTX) |=> (p0_rdata[DATA_W-1:1] == '0));

  a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
    ((p0_rd && p0_addr == A_MTX) && !(p0_wr && p0_addr == A_MTX) &&
     !(p1_wr && p1_addr == A_MTX)) |=> !mtx_state);

  a_r8_write_sets: assert property (@(posedge clk) disable iff (rst)
    ((p0_wr && p0_addr == A_MTX) || (p1_wr && p1_addr == A_MTX)) |=> mtx_state);

  a_r9_single_winner: assert property (@(posedge clk) disable iff (rst)
    (p0_rd && p0_addr == A_MTX && p1_rd && p1_addr == A_MTX) |=> !(p0_rdata[0] && p1_rdata[0]));

  a_r6_rdata_hold0: assert property (@(posedge clk) disable iff (rst)
    !p0_rd |=> $stable(p0_rdata));
endmodule

bind dual_cpu_mailbox mbx_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst),
  .p0_addr(p0_addr), .p0_wr(p0_wr), .p0_rd(p0_rd), .p0_wdata(p0_wdata), .p0_rdata(p0_rdata),
  .p1_addr(p1_addr), .p1_wr(p1_wr), .p1_rd(p1_rd), .p1_wdata(p1_wdata), .p1_rdata(p1_rdata),
  .irq0_o(irq0_o), .irq1_o(irq1_o), .mtx_state(mtx_state)
);

// File: tb/test_dual_cpu_mailbox.sv
module test_dual_cpu_mailbox;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [7:0] A_REQ0 = 8'h10, A_SET0 = 8'h14, A_CLR0 = 8'h18;
  localparam logic [7:0] A_REQ1 = 8'h30, A_SET1 = 8'h34, A_CLR1 = 8'h38;
  localparam logic [7:0] A_MTX  = 8'hF8, A_NONE = 8'h40;

  typedef struct {
    int          stamp;
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0]  p0_addr = '0, p1_addr = '0;
  logic        p0_wr = 1'b0, p0_rd = 1'b0, p1_wr = 1'b0, p1_rd = 1'b0;
  logic [31:0] p0_wdata = '0, p1_wdata = '0;
  logic [31:0] p0_rdata, p1_rdata;
  logic        irq0_o, irq1_o;

  int    cyc = 0;
  int    n_vec = 0;
  int    n_bad = 0;
  bit    finished = 1'b0;
  item_t sb [$];

  logic [31:0] m_req [2];
  logic        m_mtx;
  logic [31:0] m_rd  [2];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dual_cpu_mailbox i_dual_cpu_mailbox (
    .clk(clk), .rst(rst),
    .p0_addr(p0_addr), .p0_wr(p0_wr), .p0_rd(p0_rd), .p0_wdata(p0_wdata), .p0_rdata(p0_rdata),
    .p1_addr(p1_addr), .p1_wr(p1_wr), .p1_rd(p1_rd), .p1_wdata(p1_wdata), .p1_rdata(p1_rdata),
    .irq0_o(irq0_o), .irq1_o(irq1_o)
  );

  task automatic compare(input string tag, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  // monitor: pops items that fall due in this cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].stamp <= cyc) begin
      item_t it;
      it = sb.pop_front();
      case (it.kind)
        0: compare(it.tag, "p0_rdata", p0_rdata, it.exp);
        1: compare(it.tag, "p1_rdata", p1_rdata, it.exp);
        2: compare(it.tag, "irq0", {31'd0, irq0_o}, it.exp);
        default: compare(it.tag, "irq1", {31'd0, irq1_o}, it.exp);
      endcase
    end
  end

  function automatic logic [31:0] rd_value(input int p, input logic [7:0] a, input logic other_mtx_rd);
    if (a == A_REQ0) return m_req[0];
    if (a == A_REQ1) return m_req[1];
    if (a == A_MTX)  return {31'd0, (p == 0) ? m_mtx : (m_mtx && !other_mtx_rd)};
    return 32'd0;
  endfunction

  // driver: called at a negedge, applies one cycle on both ports
  task automatic op(input logic [7:0] a0, input logic w0, input logic r0, input logic [31:0] d0,
                    input logic [7:0] a1, input logic w1, input logic r1, input logic [31:0] d1,
                    input string tag);
    logic [31:0] setv [2];
    logic [31:0] clrv [2];
    logic        p0_mrd;
    p0_mrd = r0 && (a0 == A_MTX);
    if (r0) m_rd[0] = rd_value(0, a0, 1'b0);
    if (r1) m_rd[1] = rd_value(1, a1, p0_mrd);
    for (int b = 0; b < 2; b++) begin
      setv[b] = ((w0 && a0 == (b == 0 ? A_SET0 : A_SET1)) ? d0 : 32'd0) |
                ((w1 && a1 == (b == 0 ? A_SET0 : A_SET1)) ? d1 : 32'd0);
      clrv[b] = ((w0 && a0 == (b == 0 ? A_CLR0 : A_CLR1)) ? d0 : 32'd0) |
                ((w1 && a1 == (b == 0 ? A_CLR0 : A_CLR1)) ? d1 : 32'd0);
      m_req[b] = (m_req[b] & ~clrv[b]) | setv[b];
    end
    if ((w0 && a0 == A_MTX) || (w1 && a1 == A_MTX)) m_mtx = 1'b1;
    else if (p0_mrd || (r1 && a1 == A_MTX))          m_mtx = 1'b0;
    sb.push_back('{cyc + 1, 0, m_rd[0], tag});
    sb.push_back('{cyc + 1, 1, m_rd[1], tag});
    sb.push_back('{cyc + 1, 2, {31'd0, |m_req[0]}, tag});
    sb.push_back('{cyc + 1, 3, {31'd0, |m_req[1]}, tag});
    p0_addr = a0; p0_wr = w0; p0_rd = r0; p0_wdata = d0;
    p1_addr = a1; p1_wr = w1; p1_rd = r1; p1_wdata = d1;
    @(negedge clk);
    p0_wr = 1'b0; p0_rd = 1'b0; p1_wr = 1'b0; p1_rd = 1'b0;
  endtask

  task automatic idle(input string tag);
    op(8'h00, 1'b0, 1'b0, 32'd0, 8'h00, 1'b0, 1'b0, 32'd0, tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    m_req[0] = '0; m_req[1] = '0; m_mtx = 1'b1; m_rd[0] = '0; m_rd[1] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state at the ports
    compare("R1", "p0_rdata", p0_rdata, 32'd0);
    compare("R1", "p1_rdata", p1_rdata, 32'd0);
    compare("R1", "irqs", {30'd0, irq1_o, irq0_o}, 32'd0);
    // R1/R7: mutex reads 1 after reset, then cleared
    op(A_MTX, 1'b0, 1'b1, 32'd0, 8'h00, 1'b0, 1'b0, 32'd0, "R1");
    op(8'h00, 1'b0, 1'b0, 32'd0, A_MTX, 1'b0, 1'b1, 32'd0, "R7");
    op(A_MTX, 1'b0, 1'b1, 32'd0, 8'h00, 1'b0, 1'b0, 32'd0, "R7");
    // R8: write of zero data still sets the flag
    op(8'h00, 1'b0, 1'b0, 32'd0, A_MTX, 1'b1, 1'b0, 32'd0, "R8");
    // R9: both test at once
    op(A_MTX, 1'b0, 1'b1, 32'd0, A_MTX, 1'b0, 1'b1, 32'd0, "R9");
    op(A_MTX, 1'b0, 1'b1, 32'd0, A_MTX, 1'b0, 1'b1, 32'd0, "R9");
    // R8: write and read together: read sees old 0, flag ends 1
    op(A_MTX, 1'b1, 1'b0, 32'hFFFF_FFFF, A_MTX, 1'b0, 1'b1, 32'd0, "R8");
    op(8'h00, 1'b0, 1'b0, 32'd0, A_MTX, 1'b0, 1'b1, 32'd0, "R8");
    // R2/R4: set bits toward processor 0
    op(8'h00, 1'b0, 1'b0, 32'd0, A_SET0, 1'b1, 1'b0, 32'h0000_00A5, "R2");
    op(A_REQ0, 1'b0, 1'b1, 32'd0, 8'h00, 1'b0, 1'b0, 32'd0, "R4");
    op(A_REQ0, 1'b0, 1'b1, 32'd0, A_REQ0, 1'b0, 1'b1, 32'd0, "R6");
    op(8'h00, 1'b0, 1'b0, 32'd0, A_SET0, 1'b1, 1'b0, 32'h0100_0000, "R2");
    // R3: partial clear
    op(8'h00, 1'b0, 1'b0, 32'd0, A_CLR0, 1'b1, 1'b0, 32'h0000_0005, "R3");
    op(A_REQ0, 1'b0, 1'b1, 32'd0, 8'h00, 1'b0, 1'b0, 32'd0, "R3");
    // R5: clear-all and set of bit 3 in one cycle
    op(A_CLR0, 1'b1, 1'b0, 32'hFFFF_FFFF, A_SET0, 1'b1, 1'b0, 32'h0000_0008, "R5");
    op(8'h00, 1'b0, 1'b0, 32'd0, A_REQ0, 1'b0, 1'b1, 32'd0, "R5");
    // R4: word returns to zero, irq drops
    op(A_CLR0, 1'b1, 1'b0, 32'h0000_0008, 8'h00, 1'b0, 1'b0, 32'd0, "R4");
    idle("R4");
    // R10: both ports set disjoint bits toward processor 1
    op(A_SET1, 1'b1, 1'b0, 32'h8000_0001, A_SET1, 1'b1, 1'b0, 32'h0000_F000, "R10");
    op(8'h00, 1'b0, 1'b0, 32'd0, A_REQ1, 1'b0, 1'b1, 32'd0, "R10");
    // R6: set/clear addresses read as zero
    op(A_SET1, 1'b0, 1'b1, 32'd0, A_CLR1, 1'b0, 1'b1, 32'd0, "R6");
    // R10: unmapped write and read
    op(A_NONE, 1'b1, 1'b1, 32'hFFFF_FFFF, A_NONE, 1'b1, 1'b1, 32'h1234_5678, "R10");
    op(A_REQ0, 1'b0, 1'b1, 32'd0, A_REQ1, 1'b0, 1'b1, 32'd0, "R10");
    // R6: read data holds while idle
    idle("R6");
    idle("R6");
    // R3/R4 toward processor 1
    op(A_CLR1, 1'b1, 1'b0, 32'h8000_F001, 8'h00, 1'b0, 1'b0, 32'd0, "R3");
    op(A_REQ1, 1'b0, 1'b1, 32'd0, 8'h00, 1'b0, 1'b0, 32'd0, "R4");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule